// File: doc/BRIEF.md
# Moving-Edge Mask Overlay

This block sits in a live video path and highlights edges that have just appeared. Each input beat carries one RGB pixel together with two flags: whether the current frame has an edge at that spot, and whether the earlier frame had one there. A pixel counts as moving only when the edge is present now and was absent before. The resulting binary mask is cleaned with a 7x7 median. Because the mask is binary, that median is simply a 25-of-49 majority vote. The cleaned mask then paints the matching live pixel pure red. All other pixels leave unchanged.

The stream uses valid/ready handshakes on both sides. A start-of-frame flag marks the first pixel. Image width and height are taken from configuration inputs on that start-of-frame beat. Internally, six mask line stores and a 7x7 window produce the vote. A three-line-plus-three-pixel delay keeps the live colour aligned with the window centre. After the last input pixel of a frame, the block runs the bottom border through the pipeline by itself. The output frame therefore has exactly the same size as the input frame, and output line ends are marked.

Top module: `mdet_overlay`

## Requirements
- R1: After reset the output is not valid and the input is ready, with the block idle and waiting for a frame.
- R2: A mask bit is 1 only where the current-frame edge flag is 1 and the earlier-frame edge flag is 0. A pixel with both flags set contributes 0.
- R3: A pixel's filtered mask is 1 when at least 25 of the 49 mask bits in the 7x7 window centred on it are 1, and 0 otherwise.
- R4: Window positions outside the image count as 0. A corner pixel sees at most 16 real mask bits, and an edge pixel one step from the corner sees at most 20.
- R5: Where the filtered mask is 1, the output colour is 24'hFF0000 (red in bits 23:16, green in bits 15:8, blue in bits 7:0). Elsewhere the output colour equals the live input colour at that same position.
- R6: A frame of W by H (W from 4 to MAX_W, H from 1 to MAX_H) yields exactly W*H output beats in raster order. m_sof is set on the first beat only, and m_eol is set on every beat whose column is W-1.
- R7: While m_valid is high and m_ready is low, the output beat stays unchanged. Stalls on either side neither drop nor repeat pixels.
- R8: Width and height are sampled on the accepted start-of-frame beat. Changes to cfg_width or cfg_height during the frame do not affect it.
- R9: With m_ready held high, the W*H input pixels of a frame are accepted on consecutive cycles, one per clock.
- R10: While idle, beats with s_sof low are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | $clog2(MAX_W+1) | Frame width, sampled at start of frame |
| cfg_height | input | $clog2(MAX_H+1) | Frame height, sampled at start of frame |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with s_valid |
| s_sof | input | 1 | First pixel of a frame |
| s_rgb | input | 24 | Live pixel colour, R in 23:16, G in 15:8, B in 7:0 |
| s_edge_now | input | 1 | Edge flag of the current frame at this pixel |
| s_edge_last | input | 1 | Edge flag of the earlier frame at this pixel |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_sof | output | 1 | Output beat is the first pixel of the frame |
| m_eol | output | 1 | Output beat is the last pixel of its line |
| m_rgb | output | 24 | Output colour, painted or passed through |

## Verification
The interesting collision is a downstream stall landing in the same cycle as the window stepping across the image border. It is most telling during the self-driven flush of the bottom rows, when no input is arriving and only the output side can hold the pipeline back. The bench provokes this with random m_ready gaps and random input gaps on small frames whose new-edge regions touch the borders. It compares every output beat, including its markers, against a median computed in the bench with zero padding. A stall mishandled at the border shows up as a shifted, repeated or wrongly painted pixel.

// File: rtl/mdet_pkg.sv
package mdet_pkg;
    localparam int CW       = 8;             // bits per colour channel
    localparam int PW       = 3 * CW;        // packed pixel width
    localparam int WIN      = 7;             // vote window edge length
    localparam int HALF     = WIN / 2;       // centre offset (lines and pixels)
    localparam int CELLS    = WIN * WIN;
    localparam int VOTE_MIN = CELLS / 2 + 1; // majority threshold
    localparam int CNTW     = $clog2(CELLS + 1);
    localparam int MLINES   = WIN - 1;       // mask lines kept in storage

    localparam logic [PW-1:0] PAINT = {{CW{1'b1}}, {(2 * CW){1'b0}}};

    typedef enum logic {S_IDLE, S_RUN} fstate_t;

    typedef struct packed {
        logic [PW-1:0] rgb;
        logic          sof;
        logic          eol;
    } opix_t;

    function automatic logic [PW-1:0] paint(input logic [PW-1:0] live, input logic hit);
        return hit ? PAINT : live;
    endfunction
endpackage

// File: rtl/mdet_ctrl.sv
module mdet_ctrl import mdet_pkg::*; #(
    parameter int MAX_W = 1920,
    parameter int MAX_H = 1080,
    localparam int XW = $clog2(MAX_W + 1),
    localparam int HW = $clog2(MAX_H + 1),
    localparam int YW = $clog2(MAX_H + HALF + 2),
    localparam int AW = $clog2(MAX_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_valid,
    input  logic          s_sof,
    input  logic [XW-1:0] cfg_w,
    input  logic [HW-1:0] cfg_h,
    input  logic          out_free,
    output logic          s_ready,
    output logic          step,
    output logic          feed,
    output logic          emit,
    output logic [AW-1:0] ptr,
    output logic [XW-1:0] ox,
    output logic [YW-1:0] oy,
    output logic [XW-1:0] w_run,
    output logic [YW-1:0] h_run
);
    fstate_t       state;
    logic [XW-1:0] w_r, px, ox_r;
    logic [YW-1:0] h_r, py, oy_r;
    logic          orun;
    logic          idle, in_phase, start_out, last_out;

    always_comb begin
        idle      = (state == S_IDLE);
        in_phase  = idle || (py < h_r);
        start_out = !idle && !orun && (px == XW'(HALF)) && (py == YW'(HALF));
        emit      = orun || start_out;
        last_out  = emit && (ox_r == w_r - XW'(1)) && (oy_r == h_r - YW'(1));
        if (idle) begin
            s_ready = 1'b1;
            step    = s_valid && s_sof;
        end else begin
            s_ready = in_phase && (!emit || out_free);
            step    = (!in_phase || s_valid) && (!emit || out_free);
        end
        feed = step && in_phase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            w_r   <= '0;
            h_r   <= '0;
            px    <= '0;
            py    <= '0;
            ox_r  <= '0;
            oy_r  <= '0;
            orun  <= 1'b0;
        end else if (step) begin
            if (idle) begin
                state <= S_RUN;
                w_r   <= cfg_w;
                h_r   <= YW'(cfg_h);
                px    <= XW'(1);
                py    <= '0;
                ox_r  <= '0;
                oy_r  <= '0;
                orun  <= 1'b0;
            end else if (last_out) begin
                state <= S_IDLE;
                px    <= '0;
                py    <= '0;
                ox_r  <= '0;
                oy_r  <= '0;
                orun  <= 1'b0;
            end else begin
                if (px == w_r - XW'(1)) begin
                    px <= '0;
                    py <= py + YW'(1);
                end else begin
                    px <= px + XW'(1);
                end
                if (emit) begin
                    orun <= 1'b1;
                    if (ox_r == w_r - XW'(1)) begin
                        ox_r <= '0;
                        oy_r <= oy_r + YW'(1);
                    end else begin
                        ox_r <= ox_r + XW'(1);
                    end
                end
            end
        end
    end

    assign ptr   = px[AW-1:0];
    assign ox    = ox_r;
    assign oy    = oy_r;
    assign w_run = w_r;
    assign h_run = h_r;

    // R6: both scan columns stay inside the sampled width while a frame runs
    p_col_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN) |-> (px < w_r && ox_r < w_r));
endmodule

// File: rtl/mdet_maskbuf.sv
module mdet_maskbuf import mdet_pkg::*; #(
    parameter int MAX_W = 1920,
    parameter int AW    = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic              bit_in,
    output logic [MLINES-1:0] above
);
    // one word per column, newest line in the top bit
    logic [MLINES-1:0] mem [MAX_W];

    assign above = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= {bit_in, above[MLINES-1:1]};
    end
endmodule

// File: rtl/mdet_rgbdelay.sv
module mdet_rgbdelay import mdet_pkg::*; #(
    parameter int MAX_W = 1920,
    parameter int AW    = 11,
    parameter int LINES = HALF,
    parameter int PIX   = HALF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);
    localparam int WW = LINES * PW;

    logic [WW-1:0] mem [MAX_W];
    logic [WW-1:0] old;
    logic [PW-1:0] sr [PIX];

    assign old  = mem[addr];
    assign dout = sr[PIX-1];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= {din, old[WW-1:PW]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < PIX; k++) sr[k] <= '0;
        end else if (we) begin
            sr[0] <= old[PW-1:0];
            for (int k = 1; k < PIX; k++) sr[k] <= sr[k-1];
        end
    end
endmodule

// File: rtl/mdet_vote.sv
module mdet_vote import mdet_pkg::*; #(
    parameter int XW = 11,
    parameter int YW = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    input  logic [WIN-1:0] col,
    input  logic [XW-1:0]  ox,
    input  logic [YW-1:0]  oy,
    input  logic [XW-1:0]  w,
    input  logic [YW-1:0]  h,
    output logic           hit
);
    logic [WIN-1:0][WIN-2:0] win;
    logic [WIN-1:0][WIN-1:0] wnext;
    logic [WIN-1:0]          colv, rowv;
    logic [CNTW-1:0]         cnt;

    for (genvar j = 0; j < WIN; j++) begin : g_row
        localparam int DY = HALF - j;
        assign wnext[j] = {win[j], col[j]};
        assign rowv[j]  = (int'(oy) + DY >= 0) && (int'(oy) + DY < int'(h));
    end

    for (genvar k = 0; k < WIN; k++) begin : g_col
        localparam int DX = HALF - k;
        assign colv[k] = (int'(ox) + DX >= 0) && (int'(ox) + DX < int'(w));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else if (step) begin
            for (int j = 0; j < WIN; j++) win[j] <= wnext[j][WIN-2:0];
        end
    end

    always_comb begin
        cnt = '0;
        for (int j = 0; j < WIN; j++) begin
            for (int k = 0; k < WIN; k++) begin
                cnt = cnt + CNTW'(wnext[j][k] & rowv[j] & colv[k]);
            end
        end
        hit = (cnt >= CNTW'(VOTE_MIN));
    end

    // R4: a corner centre can never see more than a quarter-plus window
    p_corner_cap_r4: assert property (@(posedge clk) disable iff (rst)
        (ox == '0 && oy == '0) |-> (cnt <= CNTW'((HALF + 1) * (HALF + 1))));
endmodule

// File: rtl/mdet_overlay.sv
module mdet_overlay import mdet_pkg::*; #(
    parameter int MAX_W = 1920,
    parameter int MAX_H = 1080
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(MAX_W+1)-1:0]   cfg_width,
    input  logic [$clog2(MAX_H+1)-1:0]   cfg_height,
    input  logic                         s_valid,
    output logic                         s_ready,
    input  logic                         s_sof,
    input  logic [PW-1:0]                s_rgb,
    input  logic                         s_edge_now,
    input  logic                         s_edge_last,
    output logic                         m_valid,
    input  logic                         m_ready,
    output logic                         m_sof,
    output logic                         m_eol,
    output logic [PW-1:0]                m_rgb
);
    localparam int XW = $clog2(MAX_W + 1);
    localparam int YW = $clog2(MAX_H + HALF + 2);
    localparam int AW = $clog2(MAX_W);

    logic              step, feed, emit, out_free, hit, mbit;
    logic [AW-1:0]     ptr;
    logic [XW-1:0]     ox, w_run;
    logic [YW-1:0]     oy, h_run;
    logic [MLINES-1:0] above;
    logic [WIN-1:0]    col;
    logic [PW-1:0]     rgb_in, live_q;
    opix_t             out_q, out_d;
    logic              out_v;

    mdet_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_sof(s_sof),
        .cfg_w(cfg_width), .cfg_h(cfg_height), .out_free(out_free),
        .s_ready(s_ready), .step(step), .feed(feed), .emit(emit),
        .ptr(ptr), .ox(ox), .oy(oy), .w_run(w_run), .h_run(h_run)
    );

    // moving-edge mask: padding beats of the flush carry zero
    assign mbit   = feed & s_edge_now & ~s_edge_last;
    assign rgb_in = feed ? s_rgb : '0;

    mdet_maskbuf #(.MAX_W(MAX_W), .AW(AW)) u_maskbuf (
        .clk(clk), .we(step), .addr(ptr), .bit_in(mbit), .above(above)
    );

    assign col[0] = mbit;
    for (genvar j = 1; j < WIN; j++) begin : g_col
        assign col[j] = above[MLINES-j];
    end

    mdet_vote #(.XW(XW), .YW(YW)) u_vote (
        .clk(clk), .rst(rst), .step(step), .col(col),
        .ox(ox), .oy(oy), .w(w_run), .h(h_run), .hit(hit)
    );

    mdet_rgbdelay #(.MAX_W(MAX_W), .AW(AW), .LINES(HALF), .PIX(HALF)) u_rgbdelay (
        .clk(clk), .rst(rst), .we(step), .addr(ptr), .din(rgb_in), .dout(live_q)
    );

    assign out_free = !out_v || m_ready;

    always_comb begin
        out_d.rgb = paint(live_q, hit);
        out_d.sof = (ox == '0) && (oy == '0);
        out_d.eol = (ox == w_run - XW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
            out_q <= '0;
        end else if (step && emit) begin
            out_v <= 1'b1;
            out_q <= out_d;
        end else if (m_ready) begin
            out_v <= 1'b0;
        end
    end

    assign m_valid = out_v;
    assign m_rgb   = out_q.rgb;
    assign m_sof   = out_q.sof;
    assign m_eol   = out_q.eol;

    // R7: a stalled output beat is held unchanged
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_rgb) && $stable(m_sof) && $stable(m_eol)));

    // R6: a start-of-frame beat is never followed directly by another one
    p_one_sof_r6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_sof && m_ready) |=> !(m_valid && m_sof));
endmodule

// File: tb/mdet_overlay_bench.sv
module mdet_overlay_bench;
    localparam int MW   = 16;
    localparam int MH   = 16;
    localparam int XW   = $clog2(MW + 1);
    localparam int HW   = $clog2(MH + 1);
    localparam int NPIX = MW * MH;
    localparam logic [23:0] RED = 24'hFF0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [XW-1:0] cfg_width = '0;
    logic [HW-1:0] cfg_height = '0;
    logic          s_valid = 1'b0, s_sof = 1'b0, s_edge_now = 1'b0, s_edge_last = 1'b0;
    logic [23:0]   s_rgb = '0;
    logic          s_ready, m_valid, m_sof, m_eol;
    logic          m_ready = 1'b1;
    logic [23:0]   m_rgb;

    always #10 clk = ~clk;

    mdet_overlay #(.MAX_W(MW), .MAX_H(MH)) u_mdet_overlay (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_rgb(s_rgb),
        .s_edge_now(s_edge_now), .s_edge_last(s_edge_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_sof(m_sof), .m_eol(m_eol), .m_rgb(m_rgb)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int acc_first, acc_last;

    logic [23:0] f_rgb   [NPIX];
    bit          f_now   [NPIX];
    bit          f_last  [NPIX];
    logic [23:0] exp_rgb [NPIX];
    logic [23:0] got_rgb [NPIX];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", req, what, got, expv);
        end
    endtask

    task automatic build(input int pat, input int w, input int h);
        for (int i = 0; i < w * h; i++) begin
            int x = i % w;
            int y = i / w;
            f_rgb[i] = {8'(i * 37 + pat * 11), 8'(i * 5 + 3), 8'(255 - i)};
            case (pat)
                0, 3: begin f_now[i] = 1'b1; f_last[i] = 1'b0; end
                1:    begin f_now[i] = 1'b1; f_last[i] = 1'b1; end
                2: begin
                    f_now[i]  = (x >= 2 && x < 9 && y >= 1 && y < 7) ? ((i * 7 + 3) % 5 != 0)
                                                                      : ((i * 11) % 9 == 0);
                    f_last[i] = ((i * 3) % 7 == 0);
                end
                default: begin f_now[i] = (x >= w / 2); f_last[i] = (y % 4 == 0); end
            endcase
        end
        // zero-padded majority median of the new-edge mask
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int c = 0;
                for (int dy = -3; dy <= 3; dy++) begin
                    for (int dx = -3; dx <= 3; dx++) begin
                        int yy = y + dy;
                        int xx = x + dx;
                        if (yy >= 0 && yy < h && xx >= 0 && xx < w) begin
                            if (f_now[yy * w + xx] && !f_last[yy * w + xx]) c++;
                        end
                    end
                end
                exp_rgb[y * w + x] = (c >= 25) ? RED : f_rgb[y * w + x];
            end
        end
    endtask

    task automatic run_frame(input int w, input int h, input bit gap_in, input bit gap_out,
                             input bit junk, input bit alt, input string req);
        int n = w * h;
        fork
            begin : drive
                int i = 0;
                bit acc;
                cfg_width  = XW'(w);
                cfg_height = HW'(h);
                if (junk) begin
                    for (int q = 0; q < 3; q++) begin
                        @(negedge clk);
                        s_valid = 1'b1; s_sof = 1'b0; s_rgb = 24'hABCDEF;
                        s_edge_now = 1'b1; s_edge_last = 1'b0;
                        #5;
                        check(s_ready == 1'b1, "R10", "idle ready for non-sof beat", 32'(s_ready), 32'd1);
                        @(posedge clk);
                    end
                end
                while (i < n) begin
                    @(negedge clk);
                    if (alt && i > 0) begin
                        cfg_width  = XW'(5);
                        cfg_height = HW'(3);
                    end
                    if (gap_in && $urandom_range(0, 3) == 0) begin
                        s_valid = 1'b0;
                    end else begin
                        s_valid = 1'b1; s_sof = (i == 0); s_rgb = f_rgb[i];
                        s_edge_now = f_now[i]; s_edge_last = f_last[i];
                    end
                    #5;
                    acc = s_valid && s_ready;
                    if (acc) begin
                        if (i == 0) acc_first = cyc;
                        acc_last = cyc;
                    end
                    @(posedge clk);
                    if (acc) i++;
                end
                @(negedge clk);
                s_valid = 1'b0; s_sof = 1'b0;
            end
            begin : recv
                int j = 0;
                while (j < n) begin
                    @(negedge clk);
                    m_ready = gap_out ? ($urandom_range(0, 2) != 0) : 1'b1;
                    #5;
                    if (m_valid && m_ready) begin
                        check(m_rgb == exp_rgb[j] && m_sof == (j == 0) && m_eol == (j % w == w - 1),
                              req, $sformatf("pixel %0d {sof,eol,rgb}", j),
                              {6'd0, m_sof, m_eol, m_rgb},
                              {6'd0, 1'(j == 0), 1'(j % w == w - 1), exp_rgb[j]});
                        got_rgb[j] = m_rgb;
                        j++;
                    end
                end
                m_ready = 1'b1;
            end
        join
        repeat (2) @(negedge clk);
        #5;
        check(m_valid == 1'b0, "R6", "no beat after frame end", 32'(m_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got running exp finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int reds;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        check(m_valid == 1'b0, "R1", "m_valid after reset", 32'(m_valid), 32'd0);
        check(s_ready == 1'b1, "R1", "s_ready after reset", 32'(s_ready), 32'd1);

        // full new-edge frame: border thresholds (R3 R4 R5)
        build(0, 8, 8);
        run_frame(8, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R4 R5");
        check(got_rgb[9] == RED, "R4", "(1,1) sees exactly 25", 32'(got_rgb[9]), 32'(RED));
        check(got_rgb[8] == f_rgb[8], "R4", "(0,1) sees 20", 32'(got_rgb[8]), 32'(f_rgb[8]));
        check(got_rgb[0] == f_rgb[0], "R5", "corner passes live colour", 32'(got_rgb[0]), 32'(f_rgb[0]));
        check(got_rgb[27] == RED, "R3", "interior full window red", 32'(got_rgb[27]), 32'(RED));

        // edges in both frames never count (R2)
        build(1, 8, 6);
        run_frame(8, 6, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        reds = 0;
        for (int i = 0; i < 48; i++) if (got_rgb[i] == RED && f_rgb[i] != RED) reds++;
        check(reds == 0, "R2", "painted pixels with old edges", 32'(reds), 32'd0);

        // noisy mask under stalls on both sides (R7)
        build(2, 12, 9);
        run_frame(12, 9, 1'b1, 1'b1, 1'b0, 1'b0, "R7");

        // smallest frame shape (R6)
        build(3, 4, 1);
        run_frame(4, 1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");

        // idle junk then a frame with size inputs changed mid-frame (R8 R10)
        build(4, 16, 16);
        run_frame(16, 16, 1'b0, 1'b1, 1'b1, 1'b1, "R8 R10");

        // sustained rate with free downstream (R9)
        build(2, 10, 5);
        run_frame(10, 5, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        check(acc_last - acc_first == 49, "R9", "cycles from first to last accept",
              32'(acc_last - acc_first), 32'd49);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule